// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a synchronous static RAM with a burst front end. Every request input is sampled on the rising clock edge. This covers the address, the write data, three chip enables, two address strobes, the advance input and the write enables. An address strobe opens a burst of four words. The two low address bits are loaded into a 2-bit sequence counter, and the advance input then steps through the other three words. The order is linear (base plus step, wrapping inside the group of four) or interleaved (base XOR step), chosen by a mode input. Each byte lane can be written alone, or a global write stores the whole word.

Read data passes through a pipeline register. It is presented one clock after the cycle that captured the address. The output drive is a separate enable pin. Output enable and the snooze input act on that pin directly, without waiting for a clock edge. While snooze is high, the block takes no access, keeps its memory and burst state, and releases the output.

Top module: `sync_burst_sram`

## Requirements
- R1: Inputs are captured on the rising edge. Suppose a read is captured at edge N. Its data appears on `dq_out` with `dq_oe` high after edge N+1, provided `oe_n` is low and `sleep` is low at that time. `dq_oe` is low out of reset.
- R2: The block is selected only when `ce_n`=0, `ce2`=1 and `ce3_n`=0. If a strobe acts while the block is not selected, it deselects the block and ends any burst. No access is made in that cycle.
- R3: `cpu_strobe_n` low with `ce_n` low loads the address and starts a read, even when write enables are low. `cpu_strobe_n` is ignored while `ce_n` is high, so a running burst continues unchanged. `cpu_strobe_n` takes priority over `ctl_strobe_n`.
- R4: `ctl_strobe_n` low loads the address and starts an access. The access is a write when `gw_n` is low or any `bw_n` bit is low, and a read otherwise.
- R5: With `order_sel`=0 (linear), access k of a burst (k=0..3) uses low bits (base+k) mod 4. The upper address bits stay fixed, so a base of 2 yields 2,3,0,1. The counter steps when `step_n` is low and no strobe acts, and the access uses the stepped address in that same cycle.
- R6: With `order_sel`=1 (interleaved), access k uses low bits base XOR k. A base of 1 yields 1,0,3,2.
- R7: Consider a cycle inside a burst with no strobe and `step_n` high. That cycle repeats an access at the current address, read or write by the write enables.
- R8: `bw_n[i]` low writes lane i, which is bits 8i+7..8i. The other lanes keep their old contents. `gw_n` low writes all lanes whatever `bw_n` holds.
- R9: `oe_n` high forces `dq_oe` low at once, and `oe_n` low restores the drive at once. Neither change waits for a clock edge.
- R10: Suppose a deselect is captured at edge N after a read captured at edge N-1. That read still drives after edge N, and `dq_oe` goes low after edge N+1.
- R11: While `sleep` is high, `dq_oe` is low and no access is taken. Any write presented is lost, stored words are kept, and the burst counter and burst state hold. After `sleep` falls, the burst resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of pipeline and burst state |
| addr | input | AW | Word address |
| wdata | input | 8*NB | Write data |
| ce_n | input | 1 | Active-low first chip enable |
| ce2 | input | 1 | Active-high second chip enable |
| ce3_n | input | 1 | Active-low third chip enable |
| ctl_strobe_n | input | 1 | Active-low controller address strobe (read or write) |
| cpu_strobe_n | input | 1 | Active-low processor address strobe (read only) |
| step_n | input | 1 | Active-low burst advance |
| bw_n | input | NB | Active-low per-lane write enables |
| gw_n | input | 1 | Active-low global write |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Active-low asynchronous output enable |
| sleep | input | 1 | Asynchronous snooze, high blocks access |
| dq_out | output | 8*NB | Read data, zero when not driven |
| dq_oe | output | 1 | Output drive enable, low means high impedance |

## Verification
If the burst counter or its loaded base goes wrong, a read returns the word from the wrong address in the group of four. The mismatch shows on `dq_out` one clock after the access is captured. A wrong byte mask or global-write decode stays in storage unseen. It appears only on the next read of that word, which the bench places a few cycles after each write. Bad strobe priority, selection or snooze gating shows as `dq_oe` high or low in the wrong cycle. The bench catches it two edges after the faulty cycle at the latest.

// File: rtl/sync_burst_sram_pkg.sv
package sync_burst_sram_pkg;

  localparam int LANE_W = 8;

  // low address bits for step k of a burst from base
  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] k,
                                          input logic       interleave);
    logic [1:0] r;
    if (interleave) r = base ^ k;
    else            r = base + k;
    return r;
  endfunction

  // true when any write enable asks for a store
  function automatic logic wants_write(input logic gw_n_i, input logic all_lanes_off);
    return !gw_n_i || !all_lanes_off;
  endfunction

endpackage

// File: rtl/sync_burst_sram_ctrl.sv
module sync_burst_sram_ctrl
  import sync_burst_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  localparam int W = NB * LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          order_sel,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          ce_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          ctl_strobe_n,
  input  logic          cpu_strobe_n,
  input  logic          step_n,
  input  logic [NB-1:0] bw_n,
  input  logic          gw_n,
  output logic          acc_valid,
  output logic          acc_write,
  output logic [AW-1:0] acc_addr,
  output logic [NB-1:0] acc_be,
  output logic [W-1:0]  acc_wdata,
  output logic          burst_active,
  output logic [1:0]    seq_q
);

  logic          active_q;
  logic [AW-1:0] base_q;

  logic          sel, cpu_go, ctl_go, any_go;
  logic          start_ev, desel_ev, cont_ev, step_ev;
  logic [1:0]    seq_n;
  logic [AW-1:0] base_n;
  logic          valid_n, write_n;

  assign sel      = !ce_n && ce2 && !ce3_n;
  assign cpu_go   = !cpu_strobe_n && !ce_n;
  assign ctl_go   = !ctl_strobe_n && !cpu_go;
  assign any_go   = cpu_go || ctl_go;
  assign start_ev = !sleep && any_go && sel;
  assign desel_ev = !sleep && any_go && !sel;
  assign cont_ev  = !sleep && !any_go && active_q;
  assign step_ev  = cont_ev && !step_n;

  always_comb begin
    seq_n  = seq_q;
    base_n = base_q;
    if (start_ev) begin
      seq_n  = 2'd0;
      base_n = addr;
    end else if (step_ev) begin
      seq_n = seq_q + 2'd1;
    end
  end

  assign valid_n = start_ev || cont_ev;
  assign write_n = valid_n && wants_write(gw_n, &bw_n) && !(start_ev && cpu_go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      base_q    <= '0;
      seq_q     <= 2'd0;
      acc_valid <= 1'b0;
      acc_write <= 1'b0;
      acc_addr  <= '0;
      acc_be    <= '0;
      acc_wdata <= '0;
    end else begin
      if (start_ev)      active_q <= 1'b1;
      else if (desel_ev) active_q <= 1'b0;
      base_q    <= base_n;
      seq_q     <= seq_n;
      acc_valid <= valid_n;
      acc_write <= write_n;
      acc_addr  <= {base_n[AW-1:2], burst_lo(base_n[1:0], seq_n, order_sel)};
      acc_be    <= gw_n ? ~bw_n : {NB{1'b1}};
      acc_wdata <= wdata;
    end
  end

  assign burst_active = active_q;

endmodule

// File: rtl/sync_burst_sram_array.sv
module sync_burst_sram_array
  import sync_burst_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  localparam int W = NB * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [NB-1:0] acc_be,
  input  logic [W-1:0]  acc_wdata,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid
);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] wmask;

  for (genvar l = 0; l < NB; l++) begin : g_lane
    assign wmask[l*LANE_W +: LANE_W] = {LANE_W{acc_be[l]}};
  end

  always_ff @(posedge clk) begin
    if (acc_valid && acc_write)
      mem[acc_addr] <= (mem[acc_addr] & ~wmask) | (acc_wdata & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rd_data <= mem[acc_addr];
    end
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sync_burst_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  localparam int W = NB * LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          ce_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          ctl_strobe_n,
  input  logic          cpu_strobe_n,
  input  logic          step_n,
  input  logic [NB-1:0] bw_n,
  input  logic          gw_n,
  input  logic          order_sel,
  input  logic          oe_n,
  input  logic          sleep,
  output logic [W-1:0]  dq_out,
  output logic          dq_oe
);

  logic          acc_valid, acc_write;
  logic [AW-1:0] acc_addr;
  logic [NB-1:0] acc_be;
  logic [W-1:0]  acc_wdata;
  logic          burst_active;
  logic [1:0]    seq_q;
  logic [W-1:0]  rd_data;
  logic          rd_valid;

  sync_burst_sram_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .order_sel(order_sel),
    .addr(addr), .wdata(wdata), .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n),
    .ctl_strobe_n(ctl_strobe_n), .cpu_strobe_n(cpu_strobe_n), .step_n(step_n),
    .bw_n(bw_n), .gw_n(gw_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_be(acc_be), .acc_wdata(acc_wdata),
    .burst_active(burst_active), .seq_q(seq_q)
  );

  sync_burst_sram_array #(.AW(AW), .NB(NB)) u_array (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_be(acc_be), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign dq_oe  = rd_valid && !oe_n && !sleep;
  assign dq_out = dq_oe ? rd_data : '0;

endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep,
  input logic       ce_n,
  input logic       ce2,
  input logic       ce3_n,
  input logic       ctl_strobe_n,
  input logic       cpu_strobe_n,
  input logic       step_n,
  input logic       dq_oe,
  input logic       acc_valid,
  input logic       acc_write,
  input logic       burst_active,
  input logic [1:0] seq_q
);

  logic sel_w;
  assign sel_w = !ce_n && ce2 && !ce3_n;

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(acc_valid && !acc_write)); // R1

  AST_CPU_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !cpu_strobe_n && sel_w) |=> (acc_valid && !acc_write)); // R3

  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !ctl_strobe_n && cpu_strobe_n && !sel_w) |=> ##1 !dq_oe); // R10

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!acc_valid && $stable(seq_q) && $stable(burst_active))); // R11

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && burst_active && ctl_strobe_n && cpu_strobe_n && !step_n)
      |=> (seq_q == $past(seq_q) + 2'd1)); // R5

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && burst_active && ctl_strobe_n && cpu_strobe_n && step_n)
      |=> ($stable(seq_q) && acc_valid)); // R7

endmodule

bind sync_burst_sram sync_burst_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n),
  .ctl_strobe_n(ctl_strobe_n), .cpu_strobe_n(cpu_strobe_n), .step_n(step_n),
  .dq_oe(dq_oe), .acc_valid(acc_valid), .acc_write(acc_write),
  .burst_active(burst_active), .seq_q(seq_q)
);

// File: tb/sim_sync_burst_sram.sv
`timescale 1ns/1ps
module sim_sync_burst_sram;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int W  = NB * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic ce_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic ctl_strobe_n = 1'b1, cpu_strobe_n = 1'b1, step_n = 1'b1;
  logic [NB-1:0] bw_n = '1;
  logic gw_n = 1'b1, order_sel = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [W-1:0] dq_out;
  logic dq_oe;

  always #10 clk = ~clk;

  sync_burst_sram #(.AW(AW), .NB(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ce_n(ce_n), .ce2(ce2),
    .ce3_n(ce3_n), .ctl_strobe_n(ctl_strobe_n), .cpu_strobe_n(cpu_strobe_n),
    .step_n(step_n), .bw_n(bw_n), .gw_n(gw_n), .order_sel(order_sel),
    .oe_n(oe_n), .sleep(sleep), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0;
  int fails  = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  // reference state
  logic [W-1:0] ref_mem [1<<AW];
  bit           m_active = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]   m_k = 2'd0;

  // scoreboard queues
  bit           q_v [$];
  logic [W-1:0] q_d [$];
  string        q_t [$];

  function automatic logic [W-1:0] pat(input int i);
    return 32'h0101_0101 * (i + 1) ^ 32'hC3A5_0000;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // one cycle: model the captured access, push expectation, advance a cycle
  task automatic tick(input string tag, input bit late_oe_on = 1'b0);
    bit sel, cpu_go, ctl_go, acc, wr;
    logic [1:0] lo;
    logic [AW-1:0] ea;
    sel    = !ce_n && ce2 && !ce3_n;
    cpu_go = !cpu_strobe_n && !ce_n;
    ctl_go = !ctl_strobe_n && !cpu_go;
    acc = 1'b0; wr = 1'b0;
    if (!sleep) begin
      if (cpu_go || ctl_go) begin
        if (sel) begin
          m_active = 1'b1; m_base = addr; m_k = 2'd0; acc = 1'b1;
          wr = ctl_go && (!gw_n || bw_n != '1);
        end else m_active = 1'b0;
      end else if (m_active) begin
        if (!step_n) m_k = m_k + 2'd1;
        acc = 1'b1;
        wr = !gw_n || bw_n != '1;
      end
    end
    lo = order_sel ? (m_base[1:0] ^ m_k) : (m_base[1:0] + m_k);
    ea = {m_base[AW-1:2], lo};
    q_v.push_back(acc && !wr);
    q_d.push_back(ref_mem[ea]);
    q_t.push_back(tag);
    if (acc && wr)
      for (int l = 0; l < NB; l++)
        if (!gw_n || !bw_n[l]) ref_mem[ea][l*8 +: 8] = wdata[l*8 +: 8];
    if (late_oe_on) begin
      @(posedge clk); #2 oe_n = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    ctl_strobe_n = 1'b1; cpu_strobe_n = 1'b1; step_n = 1'b1;
    bw_n = '1; gw_n = 1'b1; ce_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
  endtask

  task automatic deselect(input string tag);
    quiet(); ctl_strobe_n = 1'b0; ce2 = 1'b0; tick(tag);
    quiet();
  endtask

  task automatic wr_burst_global(input logic [AW-1:0] a, input string tag);
    quiet(); addr = a; ctl_strobe_n = 1'b0; gw_n = 1'b0; wdata = pat(a); tick(tag);
    for (int k = 1; k < 4; k++) begin
      quiet(); gw_n = 1'b0; step_n = 1'b0;
      wdata = pat({a[AW-1:2], order_sel ? (a[1:0] ^ 2'(k)) : (a[1:0] + 2'(k))});
      tick(tag);
    end
    deselect(tag);
  endtask

  task automatic rd_burst(input logic [AW-1:0] a, input bit use_cpu, input string tag);
    quiet(); addr = a;
    if (use_cpu) cpu_strobe_n = 1'b0; else ctl_strobe_n = 1'b0;
    tick(tag);
    for (int k = 1; k < 4; k++) begin
      quiet(); step_n = 1'b0; tick(tag);
    end
  endtask

  // monitor: compare output against the scoreboard between edges
  always @(posedge clk) begin
    #5;
    if (mon_on && q_v.size() >= 2) begin
      bit v; logic [W-1:0] d; string t; bit exp_oe;
      v = q_v.pop_front(); d = q_d.pop_front(); t = q_t.pop_front();
      exp_oe = v && !oe_n && !sleep;
      checks++;
      if (dq_oe !== exp_oe) begin
        fails++;
        $display("FAIL %s: dq_oe=%0b expected %0b at %0t", t, dq_oe, exp_oe, $time);
      end else if (exp_oe && dq_out !== d) begin
        fails++;
        $display("FAIL %s: dq_out=%h expected %h at %0t", t, dq_out, d, $time);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;                                     // R1 reset state
    if (dq_oe !== 1'b0) begin
      fails++; $display("FAIL R1 reset: dq_oe=%0b expected 0", dq_oe);
    end
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // R8 global-write fill, linear bursts over 16 words
    order_sel = 1'b0;
    for (int b = 0; b < 16; b += 4) wr_burst_global(AW'(b), "R8");

    // R5 linear read with wrap from base 6, via processor strobe
    rd_burst(6'd6, 1'b1, "R5");
    deselect("R10");
    tick("R10"); tick("R10");

    // R6 interleaved read from base 1, and interleaved global write burst
    order_sel = 1'b1;
    rd_burst(6'd9, 1'b0, "R6");
    deselect("R6");
    wr_burst_global(6'd18, "R6");
    rd_burst(6'd18, 1'b0, "R6");
    deselect("R6");
    order_sel = 1'b0;

    // R8 partial lane write: lanes 0 and 2 only, then read back
    quiet(); addr = 6'd9; ctl_strobe_n = 1'b0; bw_n = 4'b1010; wdata = 32'hDEAD_BEEF; tick("R8");
    deselect("R8");
    // R4 controller strobe read with no write enable
    quiet(); addr = 6'd9; ctl_strobe_n = 1'b0; tick("R4");
    deselect("R4");

    // R3 processor strobe with write enables low stays a read
    quiet(); addr = 6'd4; cpu_strobe_n = 1'b0; gw_n = 1'b0; wdata = 32'h1234_5678; tick("R3");
    deselect("R3");
    rd_burst(6'd4, 1'b0, "R3");
    // R3 processor strobe ignored while ce_n high: burst continues
    quiet(); ce_n = 1'b1; cpu_strobe_n = 1'b0; addr = 6'd40; step_n = 1'b0; tick("R3");
    deselect("R3");

    // R7 suspend: step_n high repeats the address
    quiet(); addr = 6'd12; ctl_strobe_n = 1'b0; tick("R7");
    quiet(); tick("R7");
    quiet(); step_n = 1'b0; tick("R7");
    quiet(); tick("R7");
    deselect("R7");

    // R2 each enable deselects
    rd_burst(6'd0, 1'b0, "R2");
    quiet(); ctl_strobe_n = 1'b0; ce3_n = 1'b1; tick("R2");
    quiet(); step_n = 1'b0; tick("R2"); tick("R2");
    quiet(); ctl_strobe_n = 1'b0; ce_n = 1'b1; addr = 6'd3; tick("R2");
    quiet(); step_n = 1'b0; tick("R2"); tick("R2");

    // R9 output enable high blocks, then turns on mid-cycle
    rd_burst(6'd8, 1'b0, "R9");
    quiet(); oe_n = 1'b1; step_n = 1'b0; tick("R9");
    quiet(); step_n = 1'b0; tick("R9");
    quiet(); step_n = 1'b0; tick("R9", 1'b1);
    quiet(); tick("R9");
    deselect("R9");

    // R11 snooze mid-burst: write lost, counter held, output off
    quiet(); addr = 6'd13; ctl_strobe_n = 1'b0; tick("R11");
    quiet(); step_n = 1'b0; tick("R11");
    quiet(); sleep = 1'b1; step_n = 1'b0; tick("R11");
    quiet(); sleep = 1'b1; ctl_strobe_n = 1'b0; gw_n = 1'b0; addr = 6'd13; wdata = '0; tick("R11");
    quiet(); sleep = 1'b0; step_n = 1'b0; tick("R11");
    quiet(); step_n = 1'b0; tick("R11");
    deselect("R11");
    rd_burst(6'd12, 1'b0, "R11");
    deselect("R11");

    quiet();
    for (int i = 0; i < 4; i++) tick("R10");
    done = 1'b1;
    summary();
  end
endmodule